// File: doc/BRIEF.md
# Supply Supervisor and Fault Latch Sequencer

This block supervises the supply rail of a switching controller. It reads four digitised rail comparators (start, run, re-arm and clear levels), a qualified overvoltage sample and a thermal flag. From these it decides three things: when the high-voltage startup source charges the rail, when the cycle controller may switch, and whether the part sits in a permanent latched fault. An overload that collapses the rail gives an auto-recovering hiccup: switching stops, the rail bleeds down to the re-arm level, the source recharges it, and a new start is attempted. An overvoltage sample latches the part off. The source keeps cycling the rail, but switching never resumes until the rail drops below the clear level.

A soft-start ramp produces a peak-current setpoint code. The code restarts from zero on every entry into switching. It then climbs one step per `STEP_CYCLES` clocks until it saturates at full scale. A one-cycle restart pulse marks each entry, so the cycle controller can reset its own state.

The states are named as follows. `SUP_CHARGE` is source on with switching off. `SUP_RUN` is switching. `SUP_HOLD` is a thermal pause. `SUP_BLEED` is the hiccup discharge. `SUP_LK_CHARGE` and `SUP_LK_BLEED` are the latched recharge and discharge. The transitions are:
- CHARGE→RUN at the start level.
- CHARGE→HOLD at the start level while hot.
- RUN→LK_BLEED on an overvoltage sample.
- RUN→BLEED and HOLD→BLEED when the rail falls under the run level.
- RUN→HOLD when hot.
- HOLD→RUN when the thermal flag clears.
- BLEED→CHARGE at the re-arm level.
- LK_CHARGE→LK_BLEED at the start level.
- LK_BLEED→LK_CHARGE at the re-arm level.
- Either latched state→CHARGE below the clear level.

Top module: `supply_seq_top`

## Requirements
- R1: While reset is asserted and just after it, the startup source is enabled, switching is disabled, the fault flag is low, the restart pulse is low and the setpoint code is 0.
- R2: From charging, one clock after `rail_ge_start` is seen high (thermal flag low), the source turns off and switching turns on. Switching continues while `rail_ge_run` stays high, even with `rail_ge_start` low (hysteresis).
- R3: One clock after `rail_ge_run` is seen low while switching, switching stops and the source stays off. It turns back on one clock after `rail_gt_rearm` is seen low. The next `rail_ge_start` high restarts switching (hiccup).
- R4: While switching, `ovp_strobe` and `ovp_high` both high in the same cycle give `fault_latched`=1 and switching off one clock later. `ovp_high` without the strobe, or the strobe with `ovp_high` low, has no effect. This holds whether the high level comes from a real overvoltage or from an externally forced level.
- R5: While latched, the source turns on at the re-arm level and off at the start level, again and again. Switching stays off and the fault flag stays high.
- R6: One clock after `rail_gt_clear` is seen low in a latched state, the fault flag clears and the block is back in charging with the source on.
- R7: `ss_restart` is high for exactly the first clock of every entry into switching: from power-up, from a hiccup and from a thermal pause.
- R8: `ss_code` is 0 whenever switching is off. After entry into switching it equals k once k×`STEP_CYCLES` clocks have passed, never decreases, and saturates at 2^`CODE_W`−1.
- R9: A thermal flag pauses the block with source and switching off. This applies while running, or when the start level is reached while hot. Switching resumes without a latch one clock after the flag clears. If the rail falls under the run level during the pause, the block goes to the hiccup discharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_ge_start | input | 1 | Rail at or above the start level (8.4 V) |
| rail_ge_run | input | 1 | Rail at or above the run level (7.5 V) |
| rail_gt_rearm | input | 1 | Rail above the re-arm level (5.5 V) |
| rail_gt_clear | input | 1 | Rail above the latch clear level (4.0 V) |
| ovp_strobe | input | 1 | One-cycle strobe marking a valid plateau sample |
| ovp_high | input | 1 | Plateau comparator output, high at or above 5.2 V |
| therm_hot | input | 1 | Thermal shutdown flag |
| hv_src_en | output | 1 | Startup current source enable |
| sw_en | output | 1 | Switching enable to the cycle controller |
| ss_restart | output | 1 | One-cycle pulse on each entry into switching |
| fault_latched | output | 1 | Permanent fault status |
| ss_code | output | CODE_W | Soft-start peak-current setpoint code |

## Verification
The source enable, switching enable and fault flag are decoded from the state register. Each therefore changes exactly one clock edge after the comparator pattern that causes it, and the restart pulse appears in that same first switching cycle. The setpoint code reaches k after k×`STEP_CYCLES` further edges. The bench drives each input pattern at a falling edge and samples the results at the next falling edge. For the ramp, it samples again only after counting the exact number of step edges.

// File: rtl/supply_seq_pkg.sv
package supply_seq_pkg;

    typedef enum logic [2:0] {
        SUP_CHARGE    = 3'd0,
        SUP_RUN       = 3'd1,
        SUP_HOLD      = 3'd2,
        SUP_BLEED     = 3'd3,
        SUP_LK_CHARGE = 3'd4,
        SUP_LK_BLEED  = 3'd5
    } sup_state_e;

endpackage

// File: rtl/supply_seq_fsm.sv
module supply_seq_fsm
    import supply_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_ge_start,
    input  logic rail_ge_run,
    input  logic rail_gt_rearm,
    input  logic rail_gt_clear,
    input  logic ovp_strobe,
    input  logic ovp_high,
    input  logic therm_hot,
    output logic hv_src_en,
    output logic sw_en,
    output logic ss_restart,
    output logic fault_latched
);

    sup_state_e cur_q, nxt;
    logic       entry_q;
    logic       ovp_trip;

    assign ovp_trip = ovp_strobe & ovp_high;

    // Next-state decode
    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            SUP_CHARGE: begin
                if (rail_ge_start) nxt = therm_hot ? SUP_HOLD : SUP_RUN;
            end
            SUP_RUN: begin
                if (ovp_trip)          nxt = SUP_LK_BLEED;
                else if (!rail_ge_run) nxt = SUP_BLEED;
                else if (therm_hot)    nxt = SUP_HOLD;
            end
            SUP_HOLD: begin
                if (!rail_ge_run)    nxt = SUP_BLEED;
                else if (!therm_hot) nxt = SUP_RUN;
            end
            SUP_BLEED: begin
                if (!rail_gt_rearm) nxt = SUP_CHARGE;
            end
            SUP_LK_CHARGE: begin
                if (!rail_gt_clear)     nxt = SUP_CHARGE;
                else if (rail_ge_start) nxt = SUP_LK_BLEED;
            end
            SUP_LK_BLEED: begin
                if (!rail_gt_clear)      nxt = SUP_CHARGE;
                else if (!rail_gt_rearm) nxt = SUP_LK_CHARGE;
            end
            default: nxt = SUP_CHARGE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q   <= SUP_CHARGE;
            entry_q <= 1'b0;
        end else begin
            cur_q   <= nxt;
            entry_q <= (nxt == SUP_RUN) && (cur_q != SUP_RUN);
        end
    end

    // Output decode
    always_comb begin
        hv_src_en     = 1'b0;
        sw_en         = 1'b0;
        fault_latched = 1'b0;
        unique case (cur_q)
            SUP_CHARGE:    hv_src_en = 1'b1;
            SUP_RUN:       sw_en     = 1'b1;
            SUP_HOLD:      ;
            SUP_BLEED:     ;
            SUP_LK_CHARGE: begin hv_src_en = 1'b1; fault_latched = 1'b1; end
            SUP_LK_BLEED:  fault_latched = 1'b1;
            default:       hv_src_en = 1'b1;
        endcase
    end

    assign ss_restart = entry_q;

    // R2: source and switching are never on together
    p_src_sw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_src_en && sw_en));

    // R3: undervoltage while switching stops pulses on the next clock
    p_uv_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && !rail_ge_run) |=> !sw_en);

    // R4: qualified overvoltage sample latches the fault
    p_ovp_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_en && ovp_strobe && ovp_high) |=> (fault_latched && !sw_en));

    // R5: latch persists while the rail stays above the clear level
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && rail_gt_clear) |=> (fault_latched && !sw_en));

    // R6: rail below the clear level releases the latch
    p_latch_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && !rail_gt_clear) |=> (!fault_latched && hv_src_en));

    // R7: restart pulse only on the first switching cycle
    p_restart_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |-> (sw_en && !$past(sw_en)));

endmodule

// File: rtl/supply_seq_ramp.sv
module supply_seq_ramp #(
    parameter int CODE_W      = 6,
    parameter int STEP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;
    logic              step_tick;

    generate
        if (STEP_CYCLES <= 1) begin : g_every_cycle
            assign step_tick = 1'b1;
        end else begin : g_divider
            localparam int CNT_W = $clog2(STEP_CYCLES);
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYCLES - 1);
            logic [CNT_W-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             cnt_q <= '0;
                else if (!run_en || code_q == CODE_MAX) cnt_q <= '0;
                else if (cnt_q == CNT_LAST)             cnt_q <= '0;
                else                                    cnt_q <= cnt_q + 1'b1;
            end

            assign step_tick = (cnt_q == CNT_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            code_q <= '0;
        else if (!run_en)                      code_q <= '0;
        else if (step_tick && code_q != CODE_MAX) code_q <= code_q + 1'b1;
    end

    assign code = run_en ? code_q : '0;

    // R8: while running the code holds or rises by one
    p_ramp_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && $past(run_en)) |->
            ((code == $past(code)) || (code == $past(code) + 1'b1)));

endmodule

// File: rtl/supply_seq_top.sv
module supply_seq_top #(
    parameter int CODE_W      = 6,
    parameter int STEP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rail_ge_start,
    input  logic              rail_ge_run,
    input  logic              rail_gt_rearm,
    input  logic              rail_gt_clear,
    input  logic              ovp_strobe,
    input  logic              ovp_high,
    input  logic              therm_hot,
    output logic              hv_src_en,
    output logic              sw_en,
    output logic              ss_restart,
    output logic              fault_latched,
    output logic [CODE_W-1:0] ss_code
);

    supply_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .rail_ge_start (rail_ge_start),
        .rail_ge_run   (rail_ge_run),
        .rail_gt_rearm (rail_gt_rearm),
        .rail_gt_clear (rail_gt_clear),
        .ovp_strobe    (ovp_strobe),
        .ovp_high      (ovp_high),
        .therm_hot     (therm_hot),
        .hv_src_en     (hv_src_en),
        .sw_en         (sw_en),
        .ss_restart    (ss_restart),
        .fault_latched (fault_latched)
    );

    supply_seq_ramp #(
        .CODE_W      (CODE_W),
        .STEP_CYCLES (STEP_CYCLES)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (sw_en),
        .code   (ss_code)
    );

    // R7/R8: each restart begins with a zero setpoint
    p_restart_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_restart |-> (ss_code == '0));

    // R9: thermal flag blocks the switching enable one clock later
    p_therm_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot |=> !sw_en);

endmodule

// File: tb/supply_seq_top_tb_top.sv
module supply_seq_top_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int CODE_W      = 6;
    localparam int STEP_CYCLES = 16;
    localparam int CODE_MAX    = (1 << CODE_W) - 1;
    localparam int NV          = 27;

    typedef struct packed {
        logic [13:0] mv;
        logic        th;
        logic        stb;
        logic        hi;
        logic        src;
        logic        sw;
        logic        flt;
        logic        rs;
        logic [3:0]  req;
    } vec_t;

    // {rail mV, hot, strobe, ovp_high, exp src, exp sw, exp fault, exp restart, req}
    localparam vec_t TABLE [NV] = '{
        '{14'd2000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 low rail
        '{14'd6000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 charging
        '{14'd8500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 start
        '{14'd8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2}, // R2 hysteresis
        '{14'd7400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 uvlo stop
        '{14'd6000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 source off
        '{14'd5400, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 rearm
        '{14'd8000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 recharge
        '{14'd8500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7}, // R7 hiccup restart
        '{14'd8500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 hot pause
        '{14'd8500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd9}, // R9 resume
        '{14'd8500, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 strobe, low
        '{14'd8500, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4}, // R4 high, no strobe
        '{14'd8500, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 trip
        '{14'd7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 bleed
        '{14'd5400, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 recharge
        '{14'd8500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 no restart
        '{14'd5400, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 second cycle
        '{14'd8500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 still latched
        '{14'd5000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 third cycle
        '{14'd3900, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 clear
        '{14'd8500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7}, // R7 fresh start
        '{14'd8500, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 forced level
        '{14'd3000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 clear again
        '{14'd8500, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 start while hot
        '{14'd7000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 hold to bleed
        '{14'd7000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}  // R9 no resume in bleed
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_ge_start = 1'b0, rail_ge_run = 1'b0;
    logic rail_gt_rearm = 1'b0, rail_gt_clear = 1'b0;
    logic ovp_strobe = 1'b0, ovp_high = 1'b0, therm_hot = 1'b0;
    logic hv_src_en, sw_en, ss_restart, fault_latched;
    logic [CODE_W-1:0] ss_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    supply_seq_top #(.CODE_W(CODE_W), .STEP_CYCLES(STEP_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rail_ge_start(rail_ge_start), .rail_ge_run(rail_ge_run),
        .rail_gt_rearm(rail_gt_rearm), .rail_gt_clear(rail_gt_clear),
        .ovp_strobe(ovp_strobe), .ovp_high(ovp_high), .therm_hot(therm_hot),
        .hv_src_en(hv_src_en), .sw_en(sw_en), .ss_restart(ss_restart),
        .fault_latched(fault_latched), .ss_code(ss_code)
    );

    task automatic check(input int req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural rail: the millivolt level sets the four comparators
    task automatic drive(input int mv, input bit hot, input bit stb, input bit hi);
        rail_ge_start = (mv >= 8400);
        rail_ge_run   = (mv >= 7500);
        rail_gt_rearm = (mv > 5500);
        rail_gt_clear = (mv > 4000);
        therm_hot     = hot;
        ovp_strobe    = stb;
        ovp_high      = hi;
    endtask

    task automatic step_one();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check(1, hv_src_en, 1, "reset src");      // R1
        check(1, sw_en, 0, "reset sw");
        check(1, fault_latched, 0, "reset fault");
        check(1, ss_restart, 0, "reset pulse");
        check(1, ss_code, 0, "reset code");
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();

        // Table walk: drive at falling edge, sample one edge later
        for (int i = 0; i < NV; i++) begin
            drive(TABLE[i].mv, TABLE[i].th, TABLE[i].stb, TABLE[i].hi);
            step_one();
            check(TABLE[i].req, hv_src_en,     TABLE[i].src, $sformatf("row %0d src", i));
            check(TABLE[i].req, sw_en,         TABLE[i].sw,  $sformatf("row %0d sw", i));
            check(TABLE[i].req, fault_latched, TABLE[i].flt, $sformatf("row %0d fault", i));
            check(TABLE[i].req, ss_restart,    TABLE[i].rs,  $sformatf("row %0d restart", i));
        end

        // R8: soft-start ramp timing and saturation
        do_reset();
        drive(8500, 1'b0, 1'b0, 1'b0);
        step_one();
        check(8, ss_code, 0, "ramp at entry");
        check(7, ss_restart, 1, "entry pulse");
        for (int k = 1; k <= 3; k++) begin
            repeat (STEP_CYCLES) @(posedge clk);
            @(negedge clk);
            check(8, ss_code, k, "ramp step");
        end
        repeat ((CODE_MAX - 3) * STEP_CYCLES) @(posedge clk);
        @(negedge clk);
        check(8, ss_code, CODE_MAX, "ramp full scale");
        repeat (3 * STEP_CYCLES) @(posedge clk);
        @(negedge clk);
        check(8, ss_code, CODE_MAX, "ramp saturates");

        // R3/R8: hiccup clears the code, restart ramps again from zero
        drive(7400, 1'b0, 1'b0, 1'b0);
        step_one();
        check(8, ss_code, 0, "code off in bleed");
        drive(5400, 1'b0, 1'b0, 1'b0);
        step_one();
        drive(8500, 1'b0, 1'b0, 1'b0);
        step_one();
        check(7, ss_restart, 1, "hiccup pulse");
        check(8, ss_code, 0, "code after hiccup");
        step_one();
        check(7, ss_restart, 0, "pulse one cycle");
        repeat (STEP_CYCLES - 1) @(posedge clk);
        @(negedge clk);
        check(8, ss_code, 1, "ramp restarts");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule